// File: doc/BRIEF.md
# Pulse-Swallow Divider and Phase-Frequency Detector

This block is the digital heart of a frequency synthesizer loop. One of two local-oscillator inputs is chosen by a select bit and divided by a programmable ratio N through a dual-modulus 16/17 prescaler, a 4-bit swallow counter and a 12-bit main counter. Crystal ticks are divided by a fixed ratio to give the comparison edge. A phase-frequency detector compares the two divided edges. It drives a three-state main pump, where the high enable and the low enable are both off for high impedance. It also drives a sub-pump that joins in only while the phase error is large, which speeds up lockup.

All logic runs on one system clock. Each oscillator or crystal edge arrives as a one-cycle tick. The divisor is taken at reset and again each time a division period ends. Values below 272 are raised to 272.

Top module: `swallow_pfd_core`

## Requirements
- R1: The effective divisor is the `div_n` input when it is 272 or more, and 272 when it is less. Every value from 272 to 65535 is legal.
- R2: Division is pulse-swallow. With S = N[3:0] and P = N[15:4], each period has S prescaler cycles of 17 ticks followed by P-S cycles of 16 ticks. A divided edge therefore occurs on exactly every N-th selected tick.
- R3: When the divided-oscillator edge comes first, `pump_up_en` rises after the edge that registers it. It stays high until the next reference edge is registered.
- R4: When the reference edge comes first, `pump_dn_en` rises after the edge that registers it. It stays high until the next divided-oscillator edge is registered.
- R5: Divided-oscillator and reference edges registered in the same cycle produce no pump pulse. `pump_up_en` and `pump_dn_en` are never both 1. Both at 0 means high impedance.
- R6: The sub-pump enables (`sub_up_en`, `sub_dn_en`) copy the main pump direction only after the error has lasted for SUB_THR crystal ticks. Otherwise both are 0.
- R7: `sel_fm` = 1 divides `osc_fm_tick` and `sel_fm` = 0 divides `osc_am_tick`. Ticks on the unselected input have no effect.
- R8: A synchronous `rst` clears the prescaler, the counters, the detector state and the error timer. All four enables then read 0 after that edge.
- R9: A divisor change takes effect from the period that starts after the current one ends. The current period keeps the ratio it started with.
- R10: The reference edge occurs on every REF_DIV-th `xtal_tick`, counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_fm_tick | input | 1 | One-cycle tick per FM oscillator edge |
| osc_am_tick | input | 1 | One-cycle tick per AM oscillator edge |
| sel_fm | input | 1 | 1 selects the FM oscillator path, 0 the AM path |
| xtal_tick | input | 1 | One-cycle tick per crystal edge |
| div_n | input | 16 | Requested division ratio N |
| pump_up_en | output | 1 | Main pump drives high |
| pump_dn_en | output | 1 | Main pump drives low |
| sub_up_en | output | 1 | Sub-pump drives high |
| sub_dn_en | output | 1 | Sub-pump drives low |

## Verification
Divisors of 100, 300, 320, 1000 and 65535 are used. They separate the floor clamp, a period with many 17-tick cycles, the largest ratio, and a ratio whose divided edge lands in the same cycle as the reference edge. Tick rates are set so that the oscillator is fast in some runs and slow in others. This shows that the up and down pumps and the sub-pump threshold respond in each direction. Random ticks on the unselected oscillator input, a divisor change part-way through a period, and a reset during activity separate the select, reload-timing and reset behaviour. Every cycle is compared against an ideal count-to-N model.

// File: rtl/swpfd_pkg.sv
package swpfd_pkg;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned SWL_W  = 4;
  localparam int unsigned MAIN_W = DIV_W - SWL_W;
  localparam int unsigned PRE_W  = 5;
  localparam logic [DIV_W-1:0] DIV_FLOOR = 16'd272;

  typedef struct packed {
    logic up;
    logic dn;
  } drive_t;

  // R1: raise any request below the legal floor
  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] n);
    return (n < DIV_FLOOR) ? DIV_FLOOR : n;
  endfunction

  // R2: low nibble is the number of 17-tick cycles per period
  function automatic logic [SWL_W-1:0] swallow_part(input logic [DIV_W-1:0] n);
    return n[SWL_W-1:0];
  endfunction

  function automatic logic [MAIN_W-1:0] main_part(input logic [DIV_W-1:0] n);
    return n[DIV_W-1:SWL_W];
  endfunction

  // last prescaler state: 16 when swallowing (17 ticks), else 15
  function automatic logic [PRE_W-1:0] prescale_last(input logic swallowing);
    return swallowing ? PRE_W'(16) : PRE_W'(15);
  endfunction
endpackage

// File: rtl/swpfd_divider.sv
module swpfd_divider
  import swpfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_n,
  output logic             div_evt
);
  logic [PRE_W-1:0]  pres_cnt;
  logic [SWL_W-1:0]  swl_left;
  logic [MAIN_W-1:0] main_left;
  logic [DIV_W-1:0]  n_eff;
  logic              swallowing;
  logic              pres_wrap;
  logic              main_done;

  assign n_eff      = clamp_div(div_n);
  assign swallowing = (swl_left != '0);
  assign pres_wrap  = tick && (pres_cnt == prescale_last(swallowing));
  assign main_done  = pres_wrap && (main_left == MAIN_W'(1));
  assign div_evt    = main_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_cnt  <= '0;
      swl_left  <= swallow_part(n_eff);
      main_left <= main_part(n_eff);
    end else if (tick) begin
      if (pres_wrap) begin
        pres_cnt <= '0;
        if (main_done) begin
          swl_left  <= swallow_part(n_eff);   // R9: reload at period end
          main_left <= main_part(n_eff);
        end else begin
          main_left <= main_left - MAIN_W'(1);
          if (swallowing) swl_left <= swl_left - SWL_W'(1);
        end
      end else begin
        pres_cnt <= pres_cnt + PRE_W'(1);
      end
    end
  end

  // R2: prescaler never passes its 17-tick limit
  a_r2_prescale_range: assert property (@(posedge clk) disable iff (rst)
    pres_cnt <= PRE_W'(16));
  // R2: a 17th tick happens only while swallow cycles remain
  a_r2_long_only_swallow: assert property (@(posedge clk) disable iff (rst)
    (pres_cnt == PRE_W'(16)) |-> (swl_left != '0));
  // R1: floor keeps main count above the swallow count, never zero
  a_r1_main_live: assert property (@(posedge clk) disable iff (rst)
    (main_left != '0) && (main_left > MAIN_W'(swl_left)));
endmodule

// File: rtl/swpfd_refdiv.sv
module swpfd_refdiv #(
  parameter int unsigned REF_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic xtal_tick,
  output logic ref_evt
);
  localparam int unsigned REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_DIV - 1);

  logic [REF_W-1:0] ref_cnt;

  assign ref_evt = xtal_tick && (ref_cnt == REF_LAST);

  always_ff @(posedge clk) begin
    if (rst)            ref_cnt <= '0;
    else if (ref_evt)   ref_cnt <= '0;
    else if (xtal_tick) ref_cnt <= ref_cnt + REF_W'(1);
  end

  // R10: counter stays within one reference period
  a_r10_ref_range: assert property (@(posedge clk) disable iff (rst)
    ref_cnt <= REF_LAST);
endmodule

// File: rtl/swpfd_detector.sv
module swpfd_detector
  import swpfd_pkg::*;
#(
  parameter int unsigned SUB_THR = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   div_evt,
  input  logic   ref_evt,
  input  logic   xtal_tick,
  output drive_t main_drv,
  output drive_t sub_drv
);
  localparam int unsigned ERR_W = $clog2(SUB_THR + 1);
  localparam logic [ERR_W-1:0] ERR_SAT = ERR_W'(SUB_THR);

  logic             lead_v;
  logic             lead_r;
  logic             nxt_v;
  logic             nxt_r;
  logic             err_live;
  logic [ERR_W-1:0] err_cnt;
  logic             err_long;

  assign nxt_v    = lead_v | div_evt;
  assign nxt_r    = lead_r | ref_evt;
  assign err_live = lead_v | lead_r;
  assign err_long = (err_cnt == ERR_SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_v <= 1'b0;
      lead_r <= 1'b0;
    end else if (nxt_v && nxt_r) begin
      lead_v <= 1'b0;      // R5: both seen, back to high impedance
      lead_r <= 1'b0;
    end else begin
      lead_v <= nxt_v;
      lead_r <= nxt_r;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !err_live)            err_cnt <= '0;
    else if (xtal_tick && !err_long) err_cnt <= err_cnt + ERR_W'(1);
  end

  assign main_drv.up = lead_v & ~lead_r;
  assign main_drv.dn = lead_r & ~lead_v;
  assign sub_drv.up  = main_drv.up & err_long;
  assign sub_drv.dn  = main_drv.dn & err_long;

  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(main_drv.up && main_drv.dn));
  a_r6_sub_up_follows: assert property (@(posedge clk) disable iff (rst)
    sub_drv.up |-> main_drv.up);
  a_r6_sub_dn_follows: assert property (@(posedge clk) disable iff (rst)
    sub_drv.dn |-> main_drv.dn);
  a_r6_sub_needs_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(main_drv.up) |-> !sub_drv.up);
  a_r3_osc_leads: assert property (@(posedge clk) disable iff (rst)
    (div_evt && !ref_evt && !lead_r) |=> main_drv.up);
  a_r4_ref_leads: assert property (@(posedge clk) disable iff (rst)
    (ref_evt && !div_evt && !lead_v) |=> main_drv.dn);
  a_r8_reset_hiz: assert property (@(posedge clk)
    rst |=> !(main_drv.up || main_drv.dn || sub_drv.up || sub_drv.dn));
endmodule

// File: rtl/swallow_pfd_core.sv
module swallow_pfd_core
  import swpfd_pkg::*;
#(
  parameter int unsigned REF_DIV = 64,
  parameter int unsigned SUB_THR = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        osc_fm_tick,
  input  logic        osc_am_tick,
  input  logic        sel_fm,
  input  logic        xtal_tick,
  input  logic [15:0] div_n,
  output logic        pump_up_en,
  output logic        pump_dn_en,
  output logic        sub_up_en,
  output logic        sub_dn_en
);
  logic   osc_tick;
  logic   div_evt;
  logic   ref_evt;
  drive_t main_drv;
  drive_t sub_drv;

  // R7: one oscillator path feeds the divider
  assign osc_tick = sel_fm ? osc_fm_tick : osc_am_tick;

  swpfd_divider u_div (
    .clk     (clk),
    .rst     (rst),
    .tick    (osc_tick),
    .div_n   (div_n),
    .div_evt (div_evt)
  );

  swpfd_refdiv #(.REF_DIV(REF_DIV)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .xtal_tick (xtal_tick),
    .ref_evt   (ref_evt)
  );

  swpfd_detector #(.SUB_THR(SUB_THR)) u_pfd (
    .clk       (clk),
    .rst       (rst),
    .div_evt   (div_evt),
    .ref_evt   (ref_evt),
    .xtal_tick (xtal_tick),
    .main_drv  (main_drv),
    .sub_drv   (sub_drv)
  );

  assign pump_up_en = main_drv.up;
  assign pump_dn_en = main_drv.dn;
  assign sub_up_en  = sub_drv.up;
  assign sub_dn_en  = sub_drv.dn;

  // R7: a divided edge needs a tick on the selected path
  a_r7_edge_from_selected: assert property (@(posedge clk) disable iff (rst)
    div_evt |-> (sel_fm ? osc_fm_tick : osc_am_tick));
endmodule

// File: tb/tb_swallow_pfd_core.sv
module tb_swallow_pfd_core;
  localparam int REF = 64;
  localparam int THR = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_fm_tick = 1'b0;
  logic        osc_am_tick = 1'b0;
  logic        sel_fm = 1'b1;
  logic        xtal_tick = 1'b0;
  logic [15:0] div_n = 16'd272;
  logic        pump_up_en, pump_dn_en, sub_up_en, sub_dn_en;

  always #5 clk = ~clk;

  swallow_pfd_core #(.REF_DIV(REF), .SUB_THR(THR)) dut (
    .clk(clk), .rst(rst), .osc_fm_tick(osc_fm_tick), .osc_am_tick(osc_am_tick),
    .sel_fm(sel_fm), .xtal_tick(xtal_tick), .div_n(div_n),
    .pump_up_en(pump_up_en), .pump_dn_en(pump_dn_en),
    .sub_up_en(sub_up_en), .sub_dn_en(sub_dn_en)
  );

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int up_seen = 0, dn_seen = 0, sup_seen = 0, sdn_seen = 0;

  // ideal model state: count to N, no prescaler structure
  int m_cnt, m_n, m_rcnt, m_err;
  bit m_v, m_r;

  function automatic int legal_n(input int d);
    if (d >= 272) return d;
    return 272;
  endfunction

  task automatic step(input bit r, input bit fm, input bit am, input bit xt,
                      input bit sel, input int dv, input string tag);
    item_t it;
    bit tk, fv, fr, live, nv, nr, hi, lo;
    @(negedge clk);
    rst = r; osc_fm_tick = fm; osc_am_tick = am; xtal_tick = xt;
    sel_fm = sel; div_n = dv[15:0];
    if (r) begin
      m_cnt = 0; m_rcnt = 0; m_err = 0; m_v = 0; m_r = 0; m_n = legal_n(dv);
    end else begin
      tk = sel ? fm : am;
      fv = 0; fr = 0;
      if (tk) begin
        m_cnt++;
        if (m_cnt == m_n) begin fv = 1; m_cnt = 0; m_n = legal_n(dv); end
      end
      if (xt) begin
        m_rcnt++;
        if (m_rcnt == REF) begin fr = 1; m_rcnt = 0; end
      end
      live = m_v || m_r;
      if (!live) m_err = 0;
      else if (xt && m_err < THR) m_err++;
      nv = m_v || fv; nr = m_r || fr;
      if (nv && nr) begin m_v = 0; m_r = 0; end
      else begin m_v = nv; m_r = nr; end
    end
    hi = m_v && !m_r;
    lo = m_r && !m_v;
    it.exp = {hi, lo, hi && (m_err >= THR), lo && (m_err >= THR)};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares one expected item per clock, after outputs settle
  always @(posedge clk) begin
    item_t it;
    logic [3:0] act;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      act = {pump_up_en, pump_dn_en, sub_up_en, sub_dn_en};
      checks++;
      if (act[3]) up_seen++;
      if (act[2]) dn_seen++;
      if (act[1]) sup_seen++;
      if (act[0]) sdn_seen++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: {up,dn,sup,sdn} actual=%b expected=%b at %0t",
                 it.tag, act, it.exp, $time);
      end
    end
  end

  task automatic tally(input string tag, input bit ok, input int act, input int ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, ex);
    end
  endtask

  task automatic do_reset(input int dv, input bit sel);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, sel, dv, "R8 reset state");
  endtask

  initial begin
    // R8: reset state, all enables off
    do_reset(272, 1);

    // R1 R2 R4 R6: div 100 clamps to 272; reference faster, down pump + sub
    do_reset(100, 1);
    for (int i = 0; i < 3000; i++) step(0, 1, 0, 1, 1, 100, "R1 R4 R6 clamp, ref leads");
    tally("R4 down pump seen", dn_seen > 0, dn_seen, 1);
    tally("R6 down sub-pump seen", sdn_seen > 0, sdn_seen, 1);

    // R2 R3 R6: N=300 (S=12), oscillator faster than the reference
    do_reset(300, 1);
    for (int i = 0; i < 3000; i++)
      step(0, 1, 0, (i % 8) == 7, 1, 300, "R2 R3 R6 swallow N=300, osc leads");
    tally("R3 up pump seen", up_seen > 0, up_seen, 1);
    tally("R6 up sub-pump seen", sup_seen > 0, sup_seen, 1);

    // R7: AM path selected, random ticks on the FM input must not matter
    do_reset(1000, 0);
    for (int i = 0; i < 3000; i++)
      step(0, 1'($urandom), (i % 2) == 0, (i % 3) == 0, 0, 1000, "R7 AM path, FM noise");

    // R7: FM path selected, random ticks on the AM input
    do_reset(500, 1);
    for (int i = 0; i < 3000; i++)
      step(0, (i % 3) != 0, 1'($urandom), (i % 4) == 0, 1, 500, "R7 FM path, AM noise");

    // R5 R10: N=320 with crystal every 5 cycles: edges coincide, no pulse
    do_reset(320, 1);
    up_seen = 0; dn_seen = 0;
    for (int i = 0; i < 1300; i++)
      step(0, 1, 0, (i % 5) == 4, 1, 320, "R5 R10 coincident edges");
    tally("R5 no up pulse when matched", up_seen == 0, up_seen, 0);
    tally("R5 no down pulse when matched", dn_seen == 0, dn_seen, 0);

    // R9: 400 then 500 mid-period, takes effect after current period
    do_reset(400, 1);
    for (int i = 0; i < 3000; i++)
      step(0, 1, 0, (i % 7) == 0, 1, (i < 150) ? 400 : 500, "R9 divisor reload");

    // R8: reset in the middle of activity
    for (int i = 0; i < 2; i++) step(1, 1, 1, 1, 1, 500, "R8 reset during activity");
    for (int i = 0; i < 800; i++) step(0, 1, 0, 1, 1, 500, "R8 restart after reset");

    // R1 R2: largest divisor 65535
    do_reset(65535, 1);
    for (int i = 0; i < 66000; i++)
      step(0, 1, 0, (i % 512) == 0, 1, 65535, "R1 R2 max divisor");

    step(0, 0, 0, 0, 1, 65535, "R2 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule